// File: doc/BRIEF.md
# Serial Port DMA Channel Pair

This block moves bytes between system memory and one serial port, so the processor does not have to service each character. It has two channels. The receive channel stores each incoming byte in memory. The transmit channel fetches each outgoing byte from memory and loads it into the transmitter. Software programs each channel with a byte address and a number of transfers. Each channel then serves one serial-port request per transfer until its count runs out.

Each completed transfer moves the channel's address forward and reduces its count by one. When the count reaches zero, the channel sets its end-of-buffer flag. A mask can route that flag onto the interrupt line. A request that arrives while its channel's count is zero gets no response, so the serial port falls back to being handled by software. Memory is reached through a single request/acknowledge port, one transfer at a time. The channel registers, the flags and the mask all sit in a small word-addressed window.

Top module: `sdma_pair`

## Requirements
- R1: After reset, both address registers, both counts, both end-of-buffer flags, the interrupt mask and `irq` are all zero, and `mem_req` is low.
- R2: The register window uses word index `reg_addr` as follows:
  - 0: receive address.
  - 1: receive count, low 16 bits kept.
  - 2: transmit address.
  - 3: transmit count.
  - 4: read-only flags, with bit 0 for receive end-of-buffer and bit 1 for transmit end-of-buffer.
  - 5: mask set.
  - 6: mask clear.
  - 7: mask readback.

  Indices 0 to 3 read back what was written. At indices 5 and 6, a written one sets or clears that mask bit, and a written zero has no effect.
- R3: Each completed transfer adds one byte step to the channel's address and subtracts one from its count.
- R4: The transfer that takes a count from one to zero sets that channel's end-of-buffer flag. Writing a nonzero count clears the flag and arms the channel.
- R5: `irq` is high exactly when some end-of-buffer flag is set together with its mask bit.
- R6: When both channels are armed and request in the same cycle, the receive transfer is issued to memory first and the transmit transfer follows.
- R7: A request on a channel whose count is zero is ignored. No memory request is made, no acknowledge or load pulse appears, and that channel's address does not change.
- R8: A receive transfer writes `rx_data` to memory at the channel address. It then gives a one-cycle `rx_ack` pulse in the cycle after `mem_ack`.
- R9: A transmit transfer reads memory at the channel address. It then gives a one-cycle `tx_load` pulse, with the byte that was read on `tx_data`.
- R10: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Masked end-of-buffer interrupt |
| rx_req | input | 1 | Receiver holds a byte |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | Received byte has been stored |
| tx_req | input | 1 | Transmitter wants a byte |
| tx_load | output | 1 | Byte on tx_data is valid for the transmitter |
| tx_data | output | 8 | Byte fetched for the transmitter |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write (receive), 0 = read (transmit) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory transfer complete |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a receive request and a transmit request. The bench raises both on one edge while both channels are armed. It then judges the order from which pulse arrives first, `rx_ack` or `tx_load`, and from the address on the first memory request. The second pair is a transfer that ends a buffer and a mask change. The bench sets and clears the mask after the receive flag has risen, and checks `irq` after each step.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic { ST_IDLE, ST_BUSY } xfer_state_t;

   localparam int CH_RX = 0;
   localparam int CH_TX = 1;

   localparam logic [2:0] OFS_RX_ADDR  = 3'd0;
   localparam logic [2:0] OFS_RX_COUNT = 3'd1;
   localparam logic [2:0] OFS_TX_ADDR  = 3'd2;
   localparam logic [2:0] OFS_TX_COUNT = 3'd3;
   localparam logic [2:0] OFS_FLAGS    = 3'd4;
   localparam logic [2:0] OFS_MASK_SET = 3'd5;
   localparam logic [2:0] OFS_MASK_CLR = 3'd6;
   localparam logic [2:0] OFS_MASK     = 3'd7;
endpackage

// File: rtl/sdma_chan.sv
module sdma_chan #(
   parameter int AW   = 32,
   parameter int CW   = 16,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr,
   input  logic          wr_count,
   input  logic [31:0]   wdata,
   input  logic          xfer_done,
   output logic [AW-1:0] addr,
   output logic [CW-1:0] count,
   output logic          eob,
   output logic          armed
);
   localparam logic [CW-1:0] ONE = CW'(1);

   initial begin
      if (AW < 1 || AW > 32) $error("sdma_chan: AW out of range");
      if (CW < 1 || CW > 32) $error("sdma_chan: CW out of range");
      if (STEP < 1)          $error("sdma_chan: STEP must be positive");
   end

   assign armed = (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr  <= '0;
         count <= '0;
         eob   <= 1'b0;
      end else begin
         if (wr_addr)        addr <= wdata[AW-1:0];
         else if (xfer_done) addr <= addr + AW'(STEP);

         if (wr_count)       count <= wdata[CW-1:0];
         else if (xfer_done) count <= count - ONE;

         if (wr_count && wdata[CW-1:0] != '0)  eob <= 1'b0;
         else if (xfer_done && !wr_count && count == ONE) eob <= 1'b1;
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done && !wr_count |=> count == CW'($past(count) - ONE)); // R3
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done && !wr_addr |=> addr == AW'($past(addr) + AW'(STEP))); // R3
   AST_EOB_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done && !wr_count && count == ONE |=> eob); // R4
   AST_NO_XFER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> armed); // R7
endmodule

// File: rtl/sdma_arb.sv
module sdma_arb #(
   parameter bit RX_FIRST = 1'b1
) (
   input  logic [1:0] req,
   output logic [1:0] grant
);
   generate
      if (RX_FIRST) begin : g_rx_first
         assign grant[0] = req[0];
         assign grant[1] = req[1] & ~req[0];
      end else begin : g_tx_first
         assign grant[1] = req[1];
         assign grant[0] = req[0] & ~req[1];
      end
   endgenerate

   always_comb begin
      AST_ONE_GRANT: assert ($onehot0(grant)); // R6
      AST_GRANT_REQ: assert ((grant & ~req) == 2'b00); // R7
   end
endmodule

// File: rtl/sdma_pair.sv
module sdma_pair
   import sdma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int CW   = 16,
   parameter int DW   = 8,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq,
   input  logic          rx_req,
   input  logic [DW-1:0] rx_data,
   output logic          rx_ack,
   input  logic          tx_req,
   output logic          tx_load,
   output logic [DW-1:0] tx_data,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack
);
   localparam int NCH = 2;

   initial begin
      if (DW < 1 || DW > 32) $error("sdma_pair: DW out of range");
   end

   logic [NCH-1:0]  ch_wr_addr, ch_wr_count, ch_done, ch_eob, ch_armed;
   logic [AW-1:0]   ch_addr  [NCH];
   logic [CW-1:0]   ch_count [NCH];
   logic [NCH-1:0]  req_vec, grant;
   logic [NCH-1:0]  mask;
   xfer_state_t     state;
   logic            cur_tx;
   logic            finish;

   assign ch_wr_addr[CH_RX]  = reg_we && reg_addr == OFS_RX_ADDR;
   assign ch_wr_count[CH_RX] = reg_we && reg_addr == OFS_RX_COUNT;
   assign ch_wr_addr[CH_TX]  = reg_we && reg_addr == OFS_TX_ADDR;
   assign ch_wr_count[CH_TX] = reg_we && reg_addr == OFS_TX_COUNT;

   assign finish = (state == ST_BUSY) && mem_ack;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign ch_done[i] = finish && (cur_tx == (i == CH_TX));
         sdma_chan #(.AW(AW), .CW(CW), .STEP(STEP)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (ch_wr_addr[i]),
            .wr_count  (ch_wr_count[i]),
            .wdata     (reg_wdata),
            .xfer_done (ch_done[i]),
            .addr      (ch_addr[i]),
            .count     (ch_count[i]),
            .eob       (ch_eob[i]),
            .armed     (ch_armed[i])
         );
      end
   endgenerate

   assign req_vec = (state == ST_IDLE && !rx_ack && !tx_load)
                  ? {tx_req & ch_armed[CH_TX], rx_req & ch_armed[CH_RX]} : '0;

   sdma_arb #(.RX_FIRST(1'b1)) u_arb (.req(req_vec), .grant(grant));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_tx    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         rx_ack    <= 1'b0;
         tx_load   <= 1'b0;
         tx_data   <= '0;
         mask      <= '0;
      end else begin
         rx_ack  <= finish && !cur_tx;
         tx_load <= finish && cur_tx;
         if (finish && cur_tx) tx_data <= mem_rdata;
         case (state)
            ST_IDLE: if (|grant) begin
               state     <= ST_BUSY;
               cur_tx    <= grant[CH_TX];
               mem_addr  <= grant[CH_TX] ? ch_addr[CH_TX] : ch_addr[CH_RX];
               mem_wdata <= rx_data;
            end
            default: if (mem_ack) state <= ST_IDLE;
         endcase
         if (reg_we && reg_addr == OFS_MASK_SET)      mask <= mask | reg_wdata[NCH-1:0];
         else if (reg_we && reg_addr == OFS_MASK_CLR) mask <= mask & ~reg_wdata[NCH-1:0];
      end
   end

   assign mem_req = (state == ST_BUSY);
   assign mem_we  = !cur_tx;
   assign irq     = |(ch_eob & mask);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_RX_ADDR:  reg_rdata[AW-1:0] = ch_addr[CH_RX];
         OFS_RX_COUNT: reg_rdata[CW-1:0] = ch_count[CH_RX];
         OFS_TX_ADDR:  reg_rdata[AW-1:0] = ch_addr[CH_TX];
         OFS_TX_COUNT: reg_rdata[CW-1:0] = ch_count[CH_TX];
         OFS_FLAGS:    reg_rdata[NCH-1:0] = ch_eob;
         OFS_MASK:     reg_rdata[NCH-1:0] = mask;
         default:      reg_rdata = '0;
      endcase
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
   AST_RX_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ack) |-> $past(mem_ack && mem_req && mem_we)); // R8
   AST_TX_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_load) |-> $past(mem_ack && mem_req && !mem_we)); // R9
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_ack && tx_load)); // R6
endmodule

// File: tb/tb_sdma_pair.sv
module tb_sdma_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        rx_req = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ack;
   logic        tx_req = 1'b0;
   logic        tx_load;
   logic [7:0]  tx_data;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;

   logic [7:0]  mem [256];
   int          n_run = 0;
   int          n_fail = 0;
   int          cyc = 0;

   always #2.5 clk = ~clk;

   sdma_pair dut (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[7:0]];
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rx_byte(input logic [7:0] b, output bit got);
      @(negedge clk);
      rx_data = b; rx_req = 1'b1;
      got = 1'b0;
      for (int i = 0; i < 20 && !got; i++) begin
         @(negedge clk);
         if (rx_ack) got = 1'b1;
      end
      rx_req = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R1 register zero", v, 0);
      end
      check("R1 irq", 32'(irq), 0);
      check("R1 mem_req", 32'(mem_req), 0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr(3'd0, 32'h0000_0020); rd(3'd0, v); check("R2 rx addr", v, 32'h20);
      wr(3'd2, 32'hDEAD_0040); rd(3'd2, v); check("R2 tx addr", v, 32'hDEAD_0040);
      wr(3'd2, 32'h0000_0040);
      wr(3'd1, 32'h0001_0002); rd(3'd1, v); check("R2 rx count 16 bit", v, 2);
   endtask

   task automatic t_rx;
      logic [31:0] v;
      bit got;
      rx_byte(8'hA5, got);
      check("R8 rx ack seen", 32'(got), 1);
      check("R8 rx byte stored", 32'(mem[8'h20]), 32'hA5);
      rd(3'd0, v); check("R3 rx addr step", v, 32'h21);
      rd(3'd1, v); check("R3 rx count step", v, 1);
      rd(3'd4, v); check("R4 flag still clear", v, 0);
      rx_byte(8'h5A, got);
      check("R8 second byte stored", 32'(mem[8'h21]), 32'h5A);
      rd(3'd1, v); check("R3 rx count zero", v, 0);
      rd(3'd4, v); check("R4 rx flag set", v, 1);
      check("R5 irq masked off", 32'(irq), 0);
      wr(3'd5, 32'h1);
      #1 check("R5 irq on mask set", 32'(irq), 1);
      rd(3'd7, v); check("R2 mask readback", v, 1);
      wr(3'd6, 32'h0);
      #1 check("R2 clear with zero no effect", 32'(irq), 1);
      wr(3'd6, 32'h1);
      #1 check("R5 irq off after clear", 32'(irq), 0);
   endtask

   task automatic t_ignore;
      logic [31:0] v;
      int seen = 0;
      @(negedge clk);
      rx_data = 8'h77; rx_req = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (mem_req || rx_ack) seen++;
      end
      rx_req = 1'b0;
      check("R7 no response while disarmed", 32'(seen), 0);
      rd(3'd0, v); check("R7 rx addr unchanged", v, 32'h22);
      wr(3'd1, 32'h1);
      rd(3'd4, v); check("R4 rearm clears flag", v, 0);
   endtask

   task automatic t_tx;
      logic [31:0] v;
      bit got = 1'b0;
      logic [7:0] byte_seen = '0;
      mem[8'h40] = 8'h3C;
      wr(3'd3, 32'h1);
      @(negedge clk);
      tx_req = 1'b1;
      for (int i = 0; i < 20 && !got; i++) begin
         @(negedge clk);
         if (tx_load) begin got = 1'b1; byte_seen = tx_data; end
      end
      tx_req = 1'b0;
      check("R9 tx load seen", 32'(got), 1);
      check("R9 tx byte", 32'(byte_seen), 32'h3C);
      rd(3'd2, v); check("R3 tx addr step", v, 32'h41);
      rd(3'd4, v); check("R4 tx flag set", v, 2);
   endtask

   task automatic t_both;
      int rx_at = -1;
      int tx_at = -1;
      logic [31:0] first_addr = '1;
      mem[8'h70] = 8'h99;
      wr(3'd0, 32'h60);
      wr(3'd2, 32'h70);
      wr(3'd3, 32'h1);
      @(negedge clk);
      rx_data = 8'hC3; rx_req = 1'b1; tx_req = 1'b1;
      for (int i = 0; i < 40 && (rx_at < 0 || tx_at < 0); i++) begin
         @(negedge clk);
         if (mem_req && first_addr == 32'hFFFF_FFFF) first_addr = mem_addr;
         if (rx_ack) begin rx_at = i; rx_req = 1'b0; end
         if (tx_load) begin tx_at = i; tx_req = 1'b0; end
      end
      rx_req = 1'b0; tx_req = 1'b0;
      check("R6 receive issued first", first_addr, 32'h60);
      check("R6 rx before tx", 32'(rx_at >= 0 && tx_at > rx_at), 1);
      check("R8 rx byte in same-cycle case", 32'(mem[8'h60]), 32'hC3);
      check("R9 tx byte in same-cycle case", 32'(tx_data), 32'h99);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_rx();
      t_ignore();
      t_tx();
      t_both();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule